// File: doc/BRIEF.md
# Code Density Calibration Table Builder

This block turns a stream of decoded fine codes from a tapped delay line into a per-code timestamp table. Calibration relies on hits that arrive at random times relative to the sampling clock. Over many such hits, the share of hits that land on a code is proportional to the delay of the tap behind that code. The block keeps one saturating hit counter per code and stops collecting once a programmed power-of-two number of hits has been accepted.

After collection, it walks the bins once to turn each count into a delay in picoseconds. The delays of all bins together cover one coarse clock period (2400 ps by default). It then walks the bins a second time and builds a characteristic curve, which places each code at the centre of its own bin on the time axis. Codes that never received a hit, including taps that upstream bubble rejection has disabled, get zero width and add nothing to the curve.

Once the table is ready, a registered lookup port returns the curve value for any code. A new calibration can be started from the idle or ready state.

Top module: `cdt_calibrator`

## Requirements
- R1: After reset, `cal_done` is 0 and `lookup_ts` is 0.
- R2: A `start_cal` pulse that is sampled in the idle or ready state clears all bins, drops `cal_done` on the next cycle and begins hit collection.
- R3: During collection, each cycle with `code_valid` high adds one to the bin selected by `code_in` (code value k selects bin k). Collection ends after exactly 2^TOTAL_LOG2 accepted hits, which is 256 by default. Any code offered after the last accepted hit is not counted.
- R4: A bin counter saturates at 2^HIST_W-1 (255 by default) and never wraps. For example, 256 hits on one code leave that bin at 255.
- R5: The delay of bin k is floor(hits_k × PERIOD_PS / 2^TOTAL_LOG2) ps, held in DATA_W (12) bits. With the defaults, 16 hits give 150 ps and a saturated bin gives 2390 ps.
- R6: The timestamp for code n is the sum of the delays of bins 0..n-1 plus floor(delay_n / 2).
- R7: A bin with no hits has zero delay. Every code above the last hit bin therefore reads the full sum of all delays, and a code below the first hit bin reads 0.
- R8: `code_valid` has no effect outside collection. `start_cal` has no effect while the block is collecting, converting or integrating.
- R9: `cal_done` rises exactly 2×NUM_BINS+1 clock edges after the edge that accepts the last hit. While `cal_done` is high, `lookup_ts` shows the curve value of `lookup_code` one cycle after that code is presented. While `cal_done` is low, `lookup_ts` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cal | input | 1 | Pulse to clear the bins and start collecting hits |
| code_valid | input | 1 | Qualifies `code_in` as one random hit |
| code_in | input | CODE_W | Decoded fine code of the hit |
| cal_done | output | 1 | Table is built and lookups are valid |
| lookup_code | input | CODE_W | Code to translate into a timestamp |
| lookup_ts | output | DATA_W | Timestamp in ps for `lookup_code`, registered |

## Verification
The acceptance of the last hit and the end of collection fall into the same cycle. If the upstream source keeps `code_valid` asserted, codes arrive in the very cycle in which the hit counter reaches its target and the state leaves collection. The bench provokes this by holding `code_valid` high on one code for dozens of cycles past the 256th hit. It also pulses `start_cal` while the bins are being converted. It then judges the outcome by reading every code through the lookup port and comparing against a table computed from only the first 256 hits. In the same run it checks that `cal_done` rises on the exact edge given by R9.

// File: rtl/cdt_cal_pkg.sv
package cdt_cal_pkg;

    // Calibration phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_CONVERT,
        ST_INTEGRATE,
        ST_READY
    } cal_state_e;

    // Control bundle from the sequencer to the datapath
    typedef struct packed {
        logic clear;
        logic accumulate;
        logic convert;
        logic integrate;
        logic ready;
    } cal_ctrl_t;

    localparam int unsigned DEF_NUM_BINS   = 16;
    localparam int unsigned DEF_TOTAL_LOG2 = 8;
    localparam int unsigned DEF_HIST_W     = 8;
    localparam int unsigned DEF_PERIOD_PS  = 2400;
    localparam int unsigned DEF_DATA_W     = 12;

    // Scaled bin width: hits * period / 2^log2_total
    function automatic longint unsigned scaled_width(
        input longint unsigned hits,
        input longint unsigned period,
        input int unsigned     log2_total
    );
        return (hits * period) >> log2_total;
    endfunction

endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
    import cdt_cal_pkg::*;
#(
    parameter int unsigned NUM_BINS = DEF_NUM_BINS,
    localparam int unsigned IDX_W   = $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_cal,
    input  logic             hist_full,
    output cal_ctrl_t        ctrl,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

    cal_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             can_start;

    assign can_start = start_cal && (state_q == ST_IDLE || state_q == ST_READY);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE, ST_READY: begin
                if (can_start) state_d = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (hist_full) begin
                    state_d = ST_CONVERT;
                    idx_d   = '0;
                end
            end
            ST_CONVERT: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_INTEGRATE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_INTEGRATE: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_READY;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        ctrl.clear      = can_start;
        ctrl.accumulate = (state_q == ST_ACCUM);
        ctrl.convert    = (state_q == ST_CONVERT);
        ctrl.integrate  = (state_q == ST_INTEGRATE);
        ctrl.ready      = (state_q == ST_READY);
    end
    assign idx = idx_q;

    AST_READY_AFTER_INTEGRATE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.ready) |-> $past(state_q) == ST_INTEGRATE); // R9

    AST_NO_RESTART_MIDWAY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONVERT) |=> (state_q == ST_CONVERT || state_q == ST_INTEGRATE)); // R8

endmodule

// File: rtl/cdt_histogram.sv
module cdt_histogram
    import cdt_cal_pkg::*;
#(
    parameter int unsigned NUM_BINS   = DEF_NUM_BINS,
    parameter int unsigned HIST_W     = DEF_HIST_W,
    parameter int unsigned TOTAL_LOG2 = DEF_TOTAL_LOG2,
    localparam int unsigned CODE_W    = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              acc_en,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CODE_W-1:0] rd_idx,
    output logic [HIST_W-1:0] rd_count,
    output logic              full
);

    localparam int unsigned      TOT_W    = TOTAL_LOG2 + 1;
    localparam logic [TOT_W-1:0] TARGET   = TOT_W'(1) << TOTAL_LOG2;
    localparam logic [HIST_W-1:0] HIST_MAX = '1;

    logic [TOT_W-1:0]  total_q;
    logic [HIST_W-1:0] bin_q [NUM_BINS];
    logic              take;

    assign full = (total_q == TARGET);
    assign take = acc_en && code_valid && !full;

    always_ff @(posedge clk) begin
        if (rst || clear) total_q <= '0;
        else if (take)    total_q <= total_q + 1'b1;
    end

    for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                bin_q[k] <= '0;
            end else if (take && code_in == CODE_W'(k) && bin_q[k] != HIST_MAX) begin
                bin_q[k] <= bin_q[k] + 1'b1;
            end
        end

        AST_BIN_SATURATES: assert property (@(posedge clk) disable iff (rst)
            (bin_q[k] == HIST_MAX && !clear) |=> bin_q[k] == HIST_MAX); // R4
    end

    assign rd_count = bin_q[rd_idx];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        total_q <= TARGET); // R3

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!acc_en && !clear) |=> $stable(total_q)); // R8

endmodule

// File: rtl/cdt_table.sv
module cdt_table
    import cdt_cal_pkg::*;
#(
    parameter int unsigned NUM_BINS   = DEF_NUM_BINS,
    parameter int unsigned HIST_W     = DEF_HIST_W,
    parameter int unsigned TOTAL_LOG2 = DEF_TOTAL_LOG2,
    parameter int unsigned PERIOD_PS  = DEF_PERIOD_PS,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    localparam int unsigned CODE_W    = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_en,
    input  logic              integ_en,
    input  logic              ready,
    input  logic [CODE_W-1:0] idx,
    input  logic [HIST_W-1:0] rd_count,
    input  logic [CODE_W-1:0] lookup_code,
    output logic [DATA_W-1:0] lookup_ts
);

    localparam logic [DATA_W-1:0] PERIOD_V = DATA_W'(PERIOD_PS);

    logic [DATA_W-1:0] delay_q [NUM_BINS];
    logic [DATA_W-1:0] curve_q [NUM_BINS];
    logic [DATA_W-1:0] cum_q;
    logic [DATA_W-1:0] new_delay;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] cur_delay;
    logic [DATA_W-1:0] lookup_q;

    assign new_delay = DATA_W'(scaled_width(longint'(rd_count), longint'(PERIOD_PS), TOTAL_LOG2));
    assign base      = (idx == '0) ? '0 : cum_q;
    assign cur_delay = delay_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BINS; i++) begin
                delay_q[i] <= '0;
                curve_q[i] <= '0;
            end
            cum_q <= '0;
        end else begin
            if (conv_en) begin
                delay_q[idx] <= new_delay;
            end
            if (integ_en) begin
                curve_q[idx] <= base + (cur_delay >> 1);
                cum_q        <= base + cur_delay;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        lookup_q <= '0;
        else if (ready) lookup_q <= curve_q[lookup_code];
        else            lookup_q <= '0;
    end
    assign lookup_ts = lookup_q;

    AST_LOOKUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ready |=> lookup_ts == '0); // R9

    AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (rst)
        cum_q <= PERIOD_V); // R5

endmodule

// File: rtl/cdt_calibrator.sv
module cdt_calibrator
    import cdt_cal_pkg::*;
#(
    parameter int unsigned NUM_BINS   = DEF_NUM_BINS,
    parameter int unsigned HIST_W     = DEF_HIST_W,
    parameter int unsigned TOTAL_LOG2 = DEF_TOTAL_LOG2,
    parameter int unsigned PERIOD_PS  = DEF_PERIOD_PS,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    localparam int unsigned CODE_W    = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cal,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_in,
    output logic              cal_done,
    input  logic [CODE_W-1:0] lookup_code,
    output logic [DATA_W-1:0] lookup_ts
);

    cal_ctrl_t         ctrl;
    logic [CODE_W-1:0] idx;
    logic [HIST_W-1:0] rd_count;
    logic              hist_full;

    cdt_ctrl #(.NUM_BINS(NUM_BINS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_cal (start_cal),
        .hist_full (hist_full),
        .ctrl      (ctrl),
        .idx       (idx)
    );

    cdt_histogram #(
        .NUM_BINS   (NUM_BINS),
        .HIST_W     (HIST_W),
        .TOTAL_LOG2 (TOTAL_LOG2)
    ) u_hist (
        .clk        (clk),
        .rst        (rst),
        .clear      (ctrl.clear),
        .acc_en     (ctrl.accumulate),
        .code_valid (code_valid),
        .code_in    (code_in),
        .rd_idx     (idx),
        .rd_count   (rd_count),
        .full       (hist_full)
    );

    cdt_table #(
        .NUM_BINS   (NUM_BINS),
        .HIST_W     (HIST_W),
        .TOTAL_LOG2 (TOTAL_LOG2),
        .PERIOD_PS  (PERIOD_PS),
        .DATA_W     (DATA_W)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .conv_en     (ctrl.convert),
        .integ_en    (ctrl.integrate),
        .ready       (ctrl.ready),
        .idx         (idx),
        .rd_count    (rd_count),
        .lookup_code (lookup_code),
        .lookup_ts   (lookup_ts)
    );

    assign cal_done = ctrl.ready;

    AST_DONE_DROPS_ON_START: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clear) |=> !cal_done); // R2

endmodule

// File: tb/cdt_calibrator_bench.sv
module cdt_calibrator_bench;

    localparam int NB     = 16;
    localparam int CW     = 4;
    localparam int DW     = 12;
    localparam int HITS   = 256;
    localparam int HMAX   = 255;
    localparam int PERIOD = 2400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_cal = 1'b0;
    logic          code_valid = 1'b0;
    logic [CW-1:0] code_in = '0;
    logic          cal_done;
    logic [CW-1:0] lookup_code = '0;
    logic [DW-1:0] lookup_ts;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int m_hist  [NB];
    int m_curve [NB];

    always #5 clk = ~clk;

    cdt_calibrator u_cdt_calibrator (
        .clk         (clk),
        .rst         (rst),
        .start_cal   (start_cal),
        .code_valid  (code_valid),
        .code_in     (code_in),
        .cal_done    (cal_done),
        .lookup_code (lookup_code),
        .lookup_ts   (lookup_ts)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick(input int mode, input int i);
        case (mode)
            0:       return i % NB;
            1:       return (i * i + i / 3) % 8;
            default: return 3;
        endcase
    endfunction

    task automatic build_model();
        int cum = 0;
        for (int k = 0; k < NB; k++) begin
            int d = (m_hist[k] * PERIOD) / HITS;
            m_curve[k] = cum + d / 2;
            cum += d;
        end
    endtask

    task automatic start_run();
        @(negedge clk) start_cal = 1'b1;
        @(negedge clk) start_cal = 1'b0;
        for (int k = 0; k < NB; k++) m_hist[k] = 0;
    endtask

    task automatic send_hit(input int c);
        @(negedge clk);
        code_valid = 1'b1;
        code_in    = CW'(c);
        if (m_hist[c] < HMAX) m_hist[c]++;
    endtask

    // Sends the remaining hits, then checks the exact done timing (R9).
    // hold: keep code_valid high past the last hit and poke start_cal during conversion.
    task automatic finish_and_wait(input int mode, input int from, input bit gaps, input bit hold, input string tag);
        for (int i = from; i < HITS; i++) begin
            if (gaps && (i % 5 == 0)) begin
                @(negedge clk) code_valid = 1'b0;
            end
            send_hit(pick(mode, i));
        end
        @(negedge clk);
        if (hold) code_in = CW'(15);
        else      code_valid = 1'b0;
        for (int c = 1; c <= 2 * NB; c++) begin
            @(posedge clk);
            @(negedge clk);
            start_cal = (hold && c == 4);
        end
        check(cal_done == 1'b0, {tag, " R9 done not early"}, cal_done, 0);
        @(posedge clk);
        @(negedge clk);
        check(cal_done == 1'b1, {tag, " R9 done on edge"}, cal_done, 1);
        code_valid = 1'b0;
        build_model();
    endtask

    task automatic check_table(input string tag);
        for (int k = 0; k < NB; k++) begin
            @(negedge clk) lookup_code = CW'(k);
            @(negedge clk);
            check(int'(lookup_ts) == m_curve[k], {tag, " R6 curve"}, lookup_ts, m_curve[k]);
        end
    endtask

    task automatic lookup_one(input int c, output int v);
        @(negedge clk) lookup_code = CW'(c);
        @(negedge clk) v = int'(lookup_ts);
    endtask

    task automatic test_reset();
        check(cal_done == 1'b0, "R1 done after reset", cal_done, 0);
        check(lookup_ts == '0, "R1 lookup after reset", lookup_ts, 0);
        @(negedge clk) begin code_valid = 1'b1; code_in = 4'd5; end
        repeat (3) @(negedge clk);
        code_valid = 1'b0;
        check(cal_done == 1'b0, "R8 idle codes ignored", cal_done, 0);
    endtask

    task automatic test_uniform();
        int v;
        start_run();
        check(cal_done == 1'b0, "R2 collecting", cal_done, 0);
        finish_and_wait(0, 0, 1'b1, 1'b0, "uniform");
        check_table("uniform R3 R5");
        lookup_one(0, v);  check(v == 75, "R5 uniform code0", v, 75);
        lookup_one(15, v); check(v == 2325, "R5 uniform code15", v, 2325);
    endtask

    task automatic test_skewed();
        int v, w;
        start_run();
        check(cal_done == 1'b0, "R2 done drops on restart", cal_done, 0);
        finish_and_wait(1, 0, 1'b0, 1'b0, "skewed");
        check_table("skewed R6");
        lookup_one(9, v);
        lookup_one(15, w);
        check(v == w, "R7 unhit bins zero width", w, v);
        check(v == m_curve[8], "R7 tail equals full sum", v, m_curve[8]);
    endtask

    task automatic test_saturate();
        int v;
        start_run();
        finish_and_wait(2, 0, 1'b0, 1'b0, "saturate");
        lookup_one(3, v);  check(v == 1195, "R4 saturated centre", v, 1195);
        lookup_one(15, v); check(v == 2390, "R4 R5 saturated width", v, 2390);
        lookup_one(2, v);  check(v == 0, "R7 below first hit", v, 0);
    endtask

    task automatic test_overrun();
        start_run();
        finish_and_wait(0, 0, 1'b0, 1'b1, "overrun R3 R8");
        check_table("overrun R3 R8");
    endtask

    task automatic test_restart_ignored();
        start_run();
        for (int i = 0; i < 100; i++) send_hit(pick(1, i));
        @(negedge clk) begin code_valid = 1'b0; start_cal = 1'b1; lookup_code = 4'd4; end
        @(negedge clk) start_cal = 1'b0;
        check(lookup_ts == '0, "R9 lookup zero while collecting", lookup_ts, 0);
        check(cal_done == 1'b0, "R8 still collecting", cal_done, 0);
        finish_and_wait(1, 100, 1'b0, 1'b0, "restart");
        check_table("restart R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_uniform();
        test_skewed();
        test_saturate();
        test_overrun();
        test_restart_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(10 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule